// File: doc/BRIEF.md
# Register/Literal Execute ALU with Compares

This combinational execute unit forms the result of one integer operation for a 32-bit load/store processor. Operand A always comes from a register. Operand B comes either from a second register or from a 16-bit literal. The literal is sign-extended to the full word. A one-bit select input chooses between the two B sources. A 4-bit function code picks the operation. It is the low part of the opcode, so the register form and the literal form of an instruction share the same code.

The operations are wrapping add and subtract, bitwise AND/OR/XOR, an equality compare and two signed ordering compares, and three shifts. The shifts are logical left, logical right and arithmetic right. There is also an optional multiply and an optional signed divide. There are no condition flags. A compare writes a full word that holds 0 or 1. A branch or a later instruction tests that word. A build-time parameter can drop the multiplier and divider. Their codes are then flagged as unsupported, in the same way as the function codes that have no operation.

Top module: `rlx_exec_alu`

## Requirements
- R1: The function code selects the operation:
  - 0x0 add, 0x1 subtract, 0x2 multiply, 0x3 divide;
  - 0x4 equal, 0x5 less-than, 0x6 less-or-equal;
  - 0x8 AND, 0x9 OR, 0xA XOR;
  - 0xC shift left, 0xD shift right logical, 0xE shift right arithmetic.
  - For every supported code, `bad_func` is 0.
- R2: When `use_lit` is 1, operand B is `lit_imm` sign-extended from bit 15 to 32 bits. When `use_lit` is 0, operand B is `reg_b`, and `lit_imm` has no effect on the result.
- R3: AND, OR and XOR with a literal operand use the sign-extended literal, so a literal with bit 15 set has ones in bits 31..16.
- R4: Add and subtract wrap modulo 2^32. No carry, borrow or overflow output exists.
- R5: The compares return exactly 1 when the condition holds and 0 otherwise. Less-than and less-or-equal treat A and B as signed two's-complement values.
- R6: The shift count is B[4:0] (0 to 31), and the upper bits of B are ignored. The left shift and the logical right shift fill with zeros. The arithmetic right shift fills with A[31].
- R7: Multiply returns the low 32 bits of the product. Divide is signed and truncates toward zero, and it returns the low 32 bits of the quotient. A zero divisor gives 0xFFFFFFFF.
- R8: With `HAS_MULDIV` = 0, codes 0x2 and 0x3 return 0 and set `bad_func` to 1.
- R9: Codes 0x7, 0xB and 0xF return 0 and set `bad_func` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | Operand A (register value) |
| reg_b | input | 32 | Operand B register value |
| lit_imm | input | 16 | Literal field, used as B when selected |
| use_lit | input | 1 | 1 selects the sign-extended literal as B |
| func | input | 4 | Function code (low opcode bits) |
| result | output | 32 | Operation result |
| bad_func | output | 1 | Function code is unused or not built |

## Verification
The checker assumes that all inputs are known (not X) whenever it evaluates. It also assumes that the inputs only change between samples, so every check sees a settled combinational output. The bench drives each input vector shortly after a rising edge and reads the outputs at the following falling edge. Its inputs are always fully defined words, and the bench never leaves an input floating. A second instance built without the multiplier and divider receives the same stimulus style.

// File: rtl/rlx_alu_pkg.sv
package rlx_alu_pkg;
  localparam int unsigned FN_W = 4;

  localparam logic [FN_W-1:0] FN_ADD = 4'h0;
  localparam logic [FN_W-1:0] FN_SUB = 4'h1;
  localparam logic [FN_W-1:0] FN_MUL = 4'h2;
  localparam logic [FN_W-1:0] FN_DIV = 4'h3;
  localparam logic [FN_W-1:0] FN_CEQ = 4'h4;
  localparam logic [FN_W-1:0] FN_CLT = 4'h5;
  localparam logic [FN_W-1:0] FN_CLE = 4'h6;
  localparam logic [FN_W-1:0] FN_AND = 4'h8;
  localparam logic [FN_W-1:0] FN_OR  = 4'h9;
  localparam logic [FN_W-1:0] FN_XOR = 4'hA;
  localparam logic [FN_W-1:0] FN_SHL = 4'hC;
  localparam logic [FN_W-1:0] FN_SHR = 4'hD;
  localparam logic [FN_W-1:0] FN_SRA = 4'hE;
endpackage

// File: rtl/rlx_rshift_core.sv
// Logarithmic right shifter with a selectable fill bit; one stage per count bit.
module rlx_rshift_core #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SH_W   = 5
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   cnt,
  input  logic              fill,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stg [SH_W+1];

  assign stg[0] = din;

  generate
    for (genvar i = 0; i < SH_W; i++) begin : g_stage
      localparam int unsigned STEP = 1 << i;
      assign stg[i+1] = cnt[i] ? {{STEP{fill}}, stg[i][DATA_W-1:STEP]} : stg[i];
    end
  endgenerate

  assign dout = stg[SH_W];
endmodule

// File: rtl/rlx_addcmp.sv
// Shared adder for add/subtract and the compare family.
module rlx_addcmp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum_q,
  output logic [DATA_W-1:0] diff_q,
  output logic              eq_q,
  output logic              lt_q,
  output logic              le_q
);
  localparam int unsigned MSB = DATA_W - 1;

  function automatic logic [DATA_W-1:0] f_sub(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] y);
    return x + ~y + {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic f_slt(input logic [DATA_W-1:0] x,
                                 input logic [DATA_W-1:0] y,
                                 input logic [DATA_W-1:0] d);
    // differing signs decide directly; equal signs cannot overflow
    return (x[MSB] != y[MSB]) ? x[MSB] : d[MSB];
  endfunction

  assign sum_q  = a + b;
  assign diff_q = f_sub(a, b);
  assign eq_q   = (diff_q == '0);
  assign lt_q   = f_slt(a, b, diff_q);
  assign le_q   = lt_q | eq_q;
endmodule

// File: rtl/rlx_logshift.sv
// Bitwise logic and the three shifts, built on one right-shift core each.
module rlx_logshift #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SH_W   = 5
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] and_q,
  output logic [DATA_W-1:0] or_q,
  output logic [DATA_W-1:0] xor_q,
  output logic [DATA_W-1:0] shl_q,
  output logic [DATA_W-1:0] shr_q,
  output logic [DATA_W-1:0] sra_q
);
  logic [SH_W-1:0]   cnt;
  logic [DATA_W-1:0] a_rev;
  logic [DATA_W-1:0] shl_rev;

  assign cnt   = b[SH_W-1:0];
  assign and_q = a & b;
  assign or_q  = a | b;
  assign xor_q = a ^ b;

  generate
    for (genvar k = 0; k < DATA_W; k++) begin : g_rev
      assign a_rev[k] = a[DATA_W-1-k];
      assign shl_q[k] = shl_rev[DATA_W-1-k];
    end
  endgenerate

  rlx_rshift_core #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shr (
    .din(a), .cnt(cnt), .fill(1'b0), .dout(shr_q)
  );

  rlx_rshift_core #(.DATA_W(DATA_W), .SH_W(SH_W)) u_sra (
    .din(a), .cnt(cnt), .fill(a[DATA_W-1]), .dout(sra_q)
  );

  rlx_rshift_core #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shl (
    .din(a_rev), .cnt(cnt), .fill(1'b0), .dout(shl_rev)
  );
endmodule

// File: rtl/rlx_muldiv.sv
// Optional multiplier and signed divider; absent variant drives zeros.
module rlx_muldiv #(
  parameter int unsigned DATA_W     = 32,
  parameter bit          HAS_MULDIV = 1'b1
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] mul_q,
  output logic [DATA_W-1:0] div_q,
  output logic              md_present
);
  localparam int unsigned MSB = DATA_W - 1;

  function automatic logic [DATA_W-1:0] f_mag(input logic [DATA_W-1:0] v);
    return v[MSB] ? (~v + {{(DATA_W-1){1'b0}}, 1'b1}) : v;
  endfunction

  function automatic logic [DATA_W-1:0] f_sdiv(input logic [DATA_W-1:0] n,
                                               input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] q;
    if (d == '0) return '1;
    q = f_mag(n) / f_mag(d);
    return (n[MSB] ^ d[MSB]) ? (~q + {{(DATA_W-1){1'b0}}, 1'b1}) : q;
  endfunction

  generate
    if (HAS_MULDIV) begin : g_md
      assign mul_q      = a * b;
      assign div_q      = f_sdiv(a, b);
      assign md_present = 1'b1;
    end else begin : g_nomd
      assign mul_q      = '0;
      assign div_q      = '0;
      assign md_present = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/rlx_exec_alu.sv
module rlx_exec_alu
  import rlx_alu_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LIT_W      = 16,
  parameter bit          HAS_MULDIV = 1'b1
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [LIT_W-1:0]  lit_imm,
  input  logic              use_lit,
  input  logic [3:0]        func,
  output logic [DATA_W-1:0] result,
  output logic              bad_func
);
  localparam int unsigned SH_W  = $clog2(DATA_W);
  localparam int unsigned EXT_W = DATA_W - LIT_W;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] sum_q, diff_q, and_q, or_q, xor_q;
  logic [DATA_W-1:0] shl_q, shr_q, sra_q, mul_q, div_q;
  logic              eq_q, lt_q, le_q, md_present;

  // operand B source: register or sign-extended literal
  assign b_eff = use_lit ? {{EXT_W{lit_imm[LIT_W-1]}}, lit_imm} : reg_b;

  rlx_addcmp #(.DATA_W(DATA_W)) u_addcmp (
    .a(op_a), .b(b_eff), .sum_q(sum_q), .diff_q(diff_q),
    .eq_q(eq_q), .lt_q(lt_q), .le_q(le_q)
  );

  rlx_logshift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_logshift (
    .a(op_a), .b(b_eff), .and_q(and_q), .or_q(or_q), .xor_q(xor_q),
    .shl_q(shl_q), .shr_q(shr_q), .sra_q(sra_q)
  );

  rlx_muldiv #(.DATA_W(DATA_W), .HAS_MULDIV(HAS_MULDIV)) u_muldiv (
    .a(op_a), .b(b_eff), .mul_q(mul_q), .div_q(div_q), .md_present(md_present)
  );

  always_comb begin
    result   = '0;
    bad_func = 1'b0;
    unique case (func)
      FN_ADD: result = sum_q;
      FN_SUB: result = diff_q;
      FN_MUL: begin
        result   = md_present ? mul_q : '0;
        bad_func = ~md_present;
      end
      FN_DIV: begin
        result   = md_present ? div_q : '0;
        bad_func = ~md_present;
      end
      FN_CEQ: result = {{(DATA_W-1){1'b0}}, eq_q};
      FN_CLT: result = {{(DATA_W-1){1'b0}}, lt_q};
      FN_CLE: result = {{(DATA_W-1){1'b0}}, le_q};
      FN_AND: result = and_q;
      FN_OR:  result = or_q;
      FN_XOR: result = xor_q;
      FN_SHL: result = shl_q;
      FN_SHR: result = shr_q;
      FN_SRA: result = sra_q;
      default: bad_func = 1'b1;
    endcase
  end
endmodule

// File: rtl/rlx_exec_alu_chk.sv
module rlx_exec_alu_chk
  import rlx_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LIT_W  = 16
) (
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] b_eff,
  input logic [LIT_W-1:0]  lit_imm,
  input logic              use_lit,
  input logic [3:0]        func,
  input logic [DATA_W-1:0] result,
  input logic              bad_func,
  input logic              md_present
);
  localparam int unsigned SH_W = $clog2(DATA_W);
  logic [DATA_W-1:0] back;
  logic [DATA_W-1:0] hi_part;
  logic              is_valid;

  always_comb begin
    back     = result - b_eff;
    hi_part  = (result - op_a) >> (LIT_W - 1);
    is_valid = (func inside {FN_ADD, FN_SUB, FN_CEQ, FN_CLT, FN_CLE, FN_AND,
                             FN_OR, FN_XOR, FN_SHL, FN_SHR, FN_SRA}) ||
               ((func == FN_MUL || func == FN_DIV) && md_present);
    if (!$isunknown({op_a, b_eff, func, use_lit, lit_imm})) begin
      AST_ADD_INVERSE: assert (func != FN_ADD || back == op_a); // R4
      AST_LIT_SEXT: assert (!(func == FN_ADD && use_lit) ||
                            hi_part == (lit_imm[LIT_W-1] ? (DATA_W'('1) >> (LIT_W - 1)) : '0)); // R2
      AST_CMP_BOOL: assert (!(func inside {FN_CEQ, FN_CLT, FN_CLE}) ||
                            result[DATA_W-1:1] == '0); // R5
      AST_SRA_SIGN: assert (func != FN_SRA || result[DATA_W-1] == op_a[DATA_W-1]); // R6
      AST_SHL_ZEROFILL: assert (!(func == FN_SHL && b_eff[SH_W-1:0] != '0) ||
                                result[0] == 1'b0); // R6
      AST_DIV_BY_ZERO: assert (!(func == FN_DIV && md_present && b_eff == '0) ||
                               result == '1); // R7
      AST_NO_MULDIV: assert (!((func == FN_MUL || func == FN_DIV) && !md_present) ||
                             (bad_func && result == '0)); // R8
      AST_BAD_ZERO: assert (!bad_func || result == '0); // R9
      AST_VALID_CLEAN: assert (bad_func == !is_valid); // R1
    end
  end
endmodule

bind rlx_exec_alu rlx_exec_alu_chk #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_chk (
  .op_a(op_a), .b_eff(b_eff), .lit_imm(lit_imm), .use_lit(use_lit),
  .func(func), .result(result), .bad_func(bad_func), .md_present(md_present)
);

// File: tb/sim_rlx_exec_alu.sv
module sim_rlx_exec_alu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] op_a, reg_b;
  logic [15:0] lit_imm;
  logic        use_lit;
  logic [3:0]  func;
  logic [31:0] result, result1;
  logic        bad_func, bad_func1;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  rlx_exec_alu u0 (
    .op_a(op_a), .reg_b(reg_b), .lit_imm(lit_imm), .use_lit(use_lit),
    .func(func), .result(result), .bad_func(bad_func)
  );

  rlx_exec_alu #(.HAS_MULDIV(1'b0)) u1 (
    .op_a(op_a), .reg_b(reg_b), .lit_imm(lit_imm), .use_lit(use_lit),
    .func(func), .result(result1), .bad_func(bad_func1)
  );

  // {req[3:0], func[3:0], use_lit, a[31:0], b[31:0], lit[15:0], exp[31:0], exp_bad}
  localparam int NV = 29;
  localparam logic [121:0] VEC [NV] = '{
    {4'd4, 4'h0, 1'b0, 32'hFFFFFFFF, 32'h00000001, 16'h1234, 32'h00000000, 1'b0}, // R4 wrap, R2 lit ignored
    {4'd2, 4'h0, 1'b1, 32'h0000000A, 32'hDEADBEEF, 16'hFFFF, 32'h00000009, 1'b0}, // R2
    {4'd4, 4'h1, 1'b0, 32'h00000000, 32'h00000001, 16'h0000, 32'hFFFFFFFF, 1'b0}, // R4
    {4'd4, 4'h1, 1'b1, 32'h00000005, 32'h00000000, 16'h0003, 32'h00000002, 1'b0}, // R4
    {4'd3, 4'h8, 1'b1, 32'h12345678, 32'h00000000, 16'h8000, 32'h12340000, 1'b0}, // R3
    {4'd1, 4'h9, 1'b0, 32'hF0F0F0F0, 32'h0F0F0000, 16'h0000, 32'hFFFFF0F0, 1'b0}, // R1
    {4'd3, 4'hA, 1'b1, 32'h00000000, 32'h00000000, 16'h00FF, 32'h000000FF, 1'b0}, // R3
    {4'd3, 4'hA, 1'b1, 32'h00000000, 32'h00000000, 16'h8001, 32'hFFFF8001, 1'b0}, // R3
    {4'd5, 4'h4, 1'b0, 32'hDEADBEEF, 32'hDEADBEEF, 16'h0000, 32'h00000001, 1'b0}, // R5
    {4'd5, 4'h4, 1'b1, 32'hFFFFFFFF, 32'h00000000, 16'hFFFF, 32'h00000001, 1'b0}, // R5
    {4'd5, 4'h5, 1'b0, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 32'h00000001, 1'b0}, // R5 signed
    {4'd5, 4'h5, 1'b0, 32'h00000005, 32'h00000005, 16'h0000, 32'h00000000, 1'b0}, // R5
    {4'd5, 4'h6, 1'b0, 32'h00000005, 32'h00000005, 16'h0000, 32'h00000001, 1'b0}, // R5
    {4'd5, 4'h6, 1'b0, 32'h00000001, 32'h80000000, 16'h0000, 32'h00000000, 1'b0}, // R5 signed
    {4'd6, 4'hC, 1'b0, 32'h00000001, 32'h00000021, 16'h0000, 32'h00000002, 1'b0}, // R6 count masked
    {4'd6, 4'hC, 1'b0, 32'h00000001, 32'h0000001F, 16'h0000, 32'h80000000, 1'b0}, // R6
    {4'd6, 4'hD, 1'b0, 32'h80000000, 32'h0000001F, 16'h0000, 32'h00000001, 1'b0}, // R6
    {4'd6, 4'hE, 1'b0, 32'h80000000, 32'h00000004, 16'h0000, 32'hF8000000, 1'b0}, // R6
    {4'd6, 4'hE, 1'b1, 32'h7FFFFFFE, 32'h00000000, 16'h0001, 32'h3FFFFFFF, 1'b0}, // R6
    {4'd7, 4'h2, 1'b0, 32'h00010000, 32'h00010000, 16'h0000, 32'h00000000, 1'b0}, // R7
    {4'd7, 4'h2, 1'b1, 32'h00000003, 32'h00000000, 16'hFFFF, 32'hFFFFFFFD, 1'b0}, // R7
    {4'd7, 4'h3, 1'b0, 32'hFFFFFFF9, 32'h00000002, 16'h0000, 32'hFFFFFFFD, 1'b0}, // R7 trunc
    {4'd7, 4'h3, 1'b0, 32'h00000007, 32'h00000000, 16'h0000, 32'hFFFFFFFF, 1'b0}, // R7 div0
    {4'd7, 4'h3, 1'b1, 32'h00000064, 32'h00000000, 16'hFFFB, 32'hFFFFFFEC, 1'b0}, // R7
    {4'd7, 4'h3, 1'b0, 32'h80000000, 32'hFFFFFFFF, 16'h0000, 32'h80000000, 1'b0}, // R7 overflow
    {4'd9, 4'h7, 1'b0, 32'h00000005, 32'h00000005, 16'h0000, 32'h00000000, 1'b1}, // R9
    {4'd9, 4'hB, 1'b0, 32'hFFFFFFFF, 32'h12345678, 16'h0000, 32'h00000000, 1'b1}, // R9
    {4'd9, 4'hF, 1'b1, 32'hFFFFFFFF, 32'h00000000, 16'h7777, 32'h00000000, 1'b1}, // R9
    {4'd6, 4'hD, 1'b1, 32'hFFFFFFFF, 32'h00000000, 16'hFFE0, 32'hFFFFFFFF, 1'b0}  // R6 count 0
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] f, input logic ul, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] l);
    @(posedge clk);
    #1;
    func = f; use_lit = ul; op_a = a; reg_b = b; lit_imm = l;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    op_a = '0; reg_b = '0; lit_imm = '0; use_lit = 1'b0; func = 4'h0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: zero operands, add -> 0, valid
    check("R1 reset result", result, 32'h0);
    check("R1 reset bad_func", {31'b0, bad_func}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [121:0] v;
      v = VEC[i];
      apply(v[117:114], v[113], v[112:81], v[80:49], v[48:33]);
      check($sformatf("R%0d vec %0d result", v[121:118], i), result, v[32:1]);
      check($sformatf("R%0d vec %0d bad_func", v[121:118], i), {31'b0, bad_func}, {31'b0, v[0]});
    end

    // R2: literal changes with register source selected must not matter
    apply(4'h1, 1'b0, 32'h00000100, 32'h00000010, 16'h0000);
    check("R2 reg form lit=0000", result, 32'h000000F0);
    apply(4'h1, 1'b0, 32'h00000100, 32'h00000010, 16'hFFFF);
    check("R2 reg form lit=FFFF", result, 32'h000000F0);

    // R8: variant without multiply/divide
    apply(4'h2, 1'b0, 32'h00000003, 32'h00000004, 16'h0000);
    check("R8 nomd MUL result", result1, 32'h0);
    check("R8 nomd MUL bad_func", {31'b0, bad_func1}, 32'h1);
    check("R7 full MUL result", result, 32'h0000000C);
    apply(4'h3, 1'b0, 32'h00000008, 32'h00000002, 16'h0000);
    check("R8 nomd DIV result", result1, 32'h0);
    check("R8 nomd DIV bad_func", {31'b0, bad_func1}, 32'h1);
    apply(4'h0, 1'b1, 32'h00000001, 32'h0, 16'h0001);
    check("R8 nomd ADD still valid", result1, 32'h00000002);
    check("R8 nomd ADD bad_func", {31'b0, bad_func1}, 32'h0);

    // R5 compare with negative literal, signed
    apply(4'h5, 1'b1, 32'hFFFFFFF0, 32'h0, 16'hFFFF);
    check("R5 lt literal -16<-1", result, 32'h1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule